// File: doc/BRIEF.md
# Command-Loaded Up/Down Limit Counter

This block is a small counter steered by short command words. A command strobe carries a 2-bit code on a command bus. The code either zeroes the count, prepares a limit load, or selects counting upward or downward toward a stored limit. The strobe arrives from outside the clock domain. It is passed through a synchronizer, and its rising and falling transitions are found inside the clock domain. The command is taken on the rising transition. When a limit load has been prepared, the limit value is taken from the data bus on the falling transition.

Once a direction is selected, the count moves by one on each clock edge where the run input is high. When the count meets the stored limit, a done flag rises and the count freezes. Both stay that way until the next command arrives. Any new command drops done and the previous mode before its own mode takes hold, so at most one mode is active at any time.

Top module: `cmd_limit_counter`

## Requirements
- R1: A synchronous active-high reset sets the count, the stored limit, the command register and every mode flag to zero, and clears done.
- R2: The strobe passes through a two-flop synchronizer. A command on the command bus is acted on at the third rising clock edge after the strobe goes high. The count is unchanged after the first two of those edges.
- R3: Command code 2'b00 sets the count to zero, clears done, and leaves no direction active, so the count then holds whatever run does.
- R4: Command code 2'b01 arms a limit load. On the following falling strobe transition, the limit takes the data bus value present at that moment. The data bus value at the rising transition has no effect on the limit.
- R5: Command code 2'b10 selects upward counting. Each clock edge with run high adds one to the count, wrapping from 15 to 0.
- R6: Command code 2'b11 selects downward counting. Each clock edge with run high subtracts one from the count, wrapping from 0 to 15.
- R7: While run is low, or while no direction is selected, the count holds.
- R8: Done rises on the clock edge where the count steps onto the limit. After that the count holds at the limit and done stays high until the next command.
- R9: If the count already equals the limit when counting starts, done rises on the first clock edge with run high, and the count does not change.
- R10: Every new command clears done and all earlier mode flags at the edge where it is taken, so at most one of up, down or limit-arm is active.
- R11: The stored limit keeps its value across later commands other than a limit load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Asynchronous command strobe |
| run_i | input | 1 | Count enable |
| cmd_i | input | 2 | Command code: 00 clear, 01 limit load, 10 up, 11 down |
| data_i | input | 4 | Limit value, taken at the falling strobe transition |
| done_o | output | 1 | High once the count has met the limit |
| count_o | output | 4 | Current count |

## Verification
Directed sequences cover several situations that each separate one behaviour from its near neighbours:
- An upward run that stops exactly on the limit, which tells a count that freezes on time from one that overshoots by an edge.
- A downward run that wraps through zero.
- A start where the count already sits at the limit, which separates setting done without stepping from taking one extra step.
- A limit load where the data bus changes between the two strobe transitions, which shows which transition captures the limit.

A strobe applied while the count is non-zero pins down the synchronizer latency to the exact edge. After these, random command sequences with random run patterns are compared cycle by cycle against a reference model in the bench. This exposes errors in mode clearing, in wrap-around and in how long the limit is kept.

// File: rtl/cmdcnt_pkg.sv
package cmdcnt_pkg;
  typedef enum logic [1:0] {
    CMD_CLEAR = 2'b00,
    CMD_LIMIT = 2'b01,
    CMD_UP    = 2'b10,
    CMD_DOWN  = 2'b11
  } cmd_e;

  typedef struct packed {
    logic up;
    logic down;
    logic arm;
  } mode_t;

  localparam mode_t MODE_NONE = '{up: 1'b0, down: 1'b0, arm: 1'b0};

  function automatic mode_t mode_of(input cmd_e c);
    mode_t m;
    m      = MODE_NONE;
    m.up   = (c == CMD_UP);
    m.down = (c == CMD_DOWN);
    m.arm  = (c == CMD_LIMIT);
    return m;
  endfunction
endpackage

// File: rtl/strobe_edge_sync.sv
module strobe_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= strobe_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
  import cmdcnt_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  take_i,
  input  logic [1:0] cmd_i,
  output cmd_e  cmd_q_o,
  output mode_t mode_o,
  output logic  clear_req_o
);
  cmd_e  cmd_now;
  cmd_e  cmd_q;
  mode_t mode_q;

  assign cmd_now = cmd_e'(cmd_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= CMD_CLEAR;
      mode_q <= MODE_NONE;
    end else if (take_i) begin
      cmd_q  <= cmd_now;
      mode_q <= mode_of(cmd_now);
    end
  end

  assign clear_req_o = take_i && (cmd_now == CMD_CLEAR);
  assign cmd_q_o     = cmd_q;
  assign mode_o      = mode_q;
endmodule

// File: rtl/limit_count_core.sv
module limit_count_core #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             new_cmd_i,
  input  logic             clear_req_i,
  input  logic             fall_i,
  input  logic             arm_i,
  input  logic             up_i,
  input  logic             down_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] data_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] limit_o,
  output logic             done_o,
  output logic             advance_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v,
                                            input logic up);
    return up ? v + ONE : v - ONE;
  endfunction

  logic [CNT_W-1:0] count_q, limit_q, next_val;
  logic             done_q;

  assign advance_o = run_i && (up_i || down_i) && !done_q && !new_cmd_i;
  assign next_val  = step(count_q, up_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= '0;
    end else if (fall_i && arm_i) begin
      limit_q <= data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      done_q  <= 1'b0;
    end else if (new_cmd_i) begin
      done_q <= 1'b0;
      if (clear_req_i) count_q <= '0;
    end else if (advance_o) begin
      if (count_q == limit_q) begin
        done_q <= 1'b1;
      end else begin
        count_q <= next_val;
        if (next_val == limit_q) done_q <= 1'b1;
      end
    end
  end

  assign count_o = count_q;
  assign limit_o = limit_q;
  assign done_o  = done_q;
endmodule

// File: rtl/cmd_limit_counter.sv
module cmd_limit_counter
  import cmdcnt_pkg::*;
#(
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_i,
  input  logic             run_i,
  input  logic [1:0]       cmd_i,
  input  logic [CNT_W-1:0] data_i,
  output logic             done_o,
  output logic [CNT_W-1:0] count_o
);
  logic             strobe_rise;
  logic             strobe_fall;
  logic             clear_req;
  logic             count_adv;
  cmd_e             cmd_q;
  mode_t            mode_q;
  logic [CNT_W-1:0] limit_q;

  strobe_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .strobe_i(strobe_i),
    .rise_o  (strobe_rise),
    .fall_o  (strobe_fall)
  );

  cmd_decoder u_dec (
    .clk        (clk),
    .rst        (rst),
    .take_i     (strobe_rise),
    .cmd_i      (cmd_i),
    .cmd_q_o    (cmd_q),
    .mode_o     (mode_q),
    .clear_req_o(clear_req)
  );

  limit_count_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .new_cmd_i  (strobe_rise),
    .clear_req_i(clear_req),
    .fall_i     (strobe_fall),
    .arm_i      (mode_q.arm),
    .up_i       (mode_q.up),
    .down_i     (mode_q.down),
    .run_i      (run_i),
    .data_i     (data_i),
    .count_o    (count_o),
    .limit_o    (limit_q),
    .done_o     (done_o),
    .advance_o  (count_adv)
  );
endmodule

// File: rtl/cmd_limit_counter_chk.sv
module cmd_limit_counter_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             run_i,
  input logic [1:0]       cmd_i,
  input logic             strobe_rise,
  input logic             strobe_fall,
  input logic             up_q,
  input logic             down_q,
  input logic             arm_q,
  input logic [CNT_W-1:0] limit_q,
  input logic [CNT_W-1:0] count_o,
  input logic             done_o
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (count_o == '0) && !done_o && (limit_q == '0));  // R1

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    strobe_rise && (cmd_i == 2'b00) |=> (count_o == '0) && !done_o);  // R3

  AST_LIMIT_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !(strobe_fall && arm_q) |=> $stable(limit_q));  // R4

  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    up_q && run_i && !done_o && !strobe_rise && (count_o != limit_q)
    |=> count_o == $past(count_o) + CNT_W'(1));  // R5

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    down_q && run_i && !done_o && !strobe_rise && (count_o != limit_q)
    |=> count_o == $past(count_o) - CNT_W'(1));  // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !run_i && !strobe_rise |=> $stable(count_o));  // R7

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done_o && !strobe_rise |=> done_o && $stable(count_o));  // R8

  AST_DONE_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> count_o == limit_q);  // R8

  AST_ONE_MODE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({up_q, down_q, arm_q}));  // R10

  AST_CMD_DROPS_DONE: assert property (@(posedge clk) disable iff (rst)
    strobe_rise |=> !done_o);  // R10
endmodule

bind cmd_limit_counter cmd_limit_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .run_i      (run_i),
  .cmd_i      (cmd_i),
  .strobe_rise(strobe_rise),
  .strobe_fall(strobe_fall),
  .up_q       (mode_q.up),
  .down_q     (mode_q.down),
  .arm_q      (mode_q.arm),
  .limit_q    (limit_q),
  .count_o    (count_o),
  .done_o     (done_o)
);

// File: tb/cmd_limit_counter_tb.sv
`timescale 1ns/1ps
module cmd_limit_counter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe_i = 1'b0;
  logic       run_i = 1'b0;
  logic [1:0] cmd_i = 2'b00;
  logic [3:0] data_i = 4'h0;
  logic       done_o;
  logic [3:0] count_o;

  int checks = 0;
  int fails  = 0;

  logic [3:0] m_count = 4'h0;
  logic [3:0] m_limit = 4'h0;
  logic       m_up = 1'b0, m_down = 1'b0, m_done = 1'b0;

  always #2 clk = ~clk;

  cmd_limit_counter u_dut (
    .clk(clk), .rst(rst), .strobe_i(strobe_i), .run_i(run_i),
    .cmd_i(cmd_i), .data_i(data_i), .done_o(done_o), .count_o(count_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] wrap_step(input logic [3:0] v, input logic up);
    int t;
    t = up ? (int'(v) + 1) % 16 : (int'(v) + 15) % 16;
    return 4'(t);
  endfunction

  task automatic model_step();
    if (m_done || !(m_up || m_down)) return;
    if (m_count == m_limit) m_done = 1'b1;
    else begin
      m_count = wrap_step(m_count, m_up);
      if (m_count == m_limit) m_done = 1'b1;
    end
  endtask

  task automatic model_cmd(input logic [1:0] c, input logic [3:0] dfall);
    m_done = 1'b0;
    m_up   = (c == 2'b10);
    m_down = (c == 2'b11);
    if (c == 2'b00) m_count = 4'h0;
    if (c == 2'b01) m_limit = dfall;
  endtask

  task automatic send_cmd(input logic [1:0] c, input logic [3:0] drise,
                          input logic [3:0] dfall);
    run_i = 1'b0; cmd_i = c; data_i = drise; strobe_i = 1'b1;
    repeat (4) @(negedge clk);
    data_i = dfall; strobe_i = 1'b0;
    repeat (4) @(negedge clk);
    model_cmd(c, dfall);
  endtask

  task automatic run_cycles(input int n, input bit random_run, input string req);
    for (int i = 0; i < n; i++) begin
      logic r;
      r = random_run ? (($urandom % 4) != 0) : 1'b1;
      run_i = r;
      @(negedge clk);
      if (r) model_step();
      check(req, count_o, m_count);
      check(req, done_o, m_done);
    end
    run_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 count after reset", count_o, 0);
    check("R1 done after reset", done_o, 0);

    // R11 and R5: load limit 9, count up to 5
    send_cmd(2'b01, 4'h2, 4'h9);
    send_cmd(2'b10, 4'h0, 4'h0);
    run_cycles(5, 0, "R5 up count");
    check("R5 count after five steps", count_o, 5);

    // R2: clear takes effect on the third edge after the strobe rises
    cmd_i = 2'b00; strobe_i = 1'b1;
    @(negedge clk);
    check("R2 after first edge", count_o, 5);
    @(negedge clk);
    check("R2 after second edge", count_o, 5);
    @(negedge clk);
    check("R2 R3 after third edge", count_o, 0);
    @(negedge clk);
    strobe_i = 1'b0;
    repeat (4) @(negedge clk);
    model_cmd(2'b00, 4'h0);
    run_cycles(3, 0, "R3 no direction after clear");

    // R4: the data at the rising transition is ignored
    send_cmd(2'b01, 4'h3, 4'h7);
    send_cmd(2'b10, 4'h0, 4'h0);
    run_cycles(7, 0, "R8 up to limit");
    check("R4 R8 count equals fall data", count_o, 7);
    check("R8 done at limit", done_o, 1);
    run_cycles(3, 0, "R8 hold after done");

    // R10, R9: new command drops done; already at limit
    send_cmd(2'b11, 4'h0, 4'h0);
    check("R10 done cleared by command", done_o, 0);
    run_cycles(1, 0, "R9 already equal");
    check("R9 count unchanged", count_o, 7);
    check("R9 done set", done_o, 1);

    // R6 wrap downward, R11 limit kept across clear
    send_cmd(2'b00, 4'h5, 4'hA);
    send_cmd(2'b11, 4'h0, 4'h0);
    run_cycles(9, 0, "R6 down with wrap");
    check("R6 R11 down reaches kept limit", count_o, 7);
    check("R6 done", done_o, 1);

    // R5 wrap upward: limit 1 from 7 passes 15 -> 0
    send_cmd(2'b01, 4'h0, 4'h1);
    send_cmd(2'b10, 4'h0, 4'h0);
    run_cycles(10, 0, "R5 up with wrap");
    check("R5 wrap count", count_o, 1);

    // R7: run low holds
    send_cmd(2'b11, 4'h0, 4'h0);
    repeat (5) @(negedge clk);
    check("R7 hold with run low", count_o, 1);

    // random command sequences
    for (int k = 0; k < 80; k++) begin
      logic [1:0] c;
      logic [3:0] dr, df;
      c  = 2'($urandom);
      dr = 4'($urandom);
      df = 4'($urandom);
      send_cmd(c, dr, df);
      run_cycles(int'($urandom % 24), 1, "R5 R6 R7 R8 R10 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule